// File: doc/BRIEF.md
# Single-stream DMA transfer engine

This block is one DMA stream that copies a run of data units from a source address range to a destination address range over a pipelined master bus. The bus uses separate address and data phases, and a slave stall signal stretches the data phase. Software loads a source base, a destination base and a unit count through a small register write port. It then writes the control word with the enable bit set. The engine copies the bases into its current-address registers and splits the job into bursts. For each burst it gathers every source beat into an internal burst buffer before it writes any of that burst to the destination.

When the last unit has been written, the engine raises a one-cycle done pulse and clears its own enable bit. Software may clear the enable bit at any time during a transfer. The bus request then drops at once and the stream returns to idle with its sequencing state cleared. The next enable starts a new transfer from the bases.

The register write port selects a register with `cfg_sel`. Select 0 is the control word, select 1 the source base, select 2 the destination base and select 3 the unit count. The control word has these fields:

- bit 0: enable
- bits 2:1: unit size
- bits 4:3: burst length
- bit 5: source increment
- bit 6: destination increment

Top module: `dma_stream`

## Requirements
- R1: After reset `en_o`, `err_o`, `done_o` and `m_req_o` are all 0.
- R2: The unit size code is 00 for 1 byte, 01 for 2 bytes and 10 for 4 bytes, and every bus beat carries that code on `m_size_o`. With its increment bit set, each current address steps by the unit size after every beat on its side. After a transfer of N units, that address therefore reads base + N × size.
- R3: With an increment bit clear, the matching current address stays at its base for the whole transfer.
- R4: The current source address advances in the cycle that follows an accepted read address phase (`m_req_o`=1 and `m_ready_i`=1 at a clock edge). It does not wait for the data phase.
- R5: The burst code is 00 for 1 beat, 01 for 4 beats, 10 for 8 beats and 11 for 16 beats. All reads of a burst are issued before any write of that burst. The longest run of consecutive read beats therefore equals min(burst length, count).
- R6: A transfer moves exactly the count in read beats and the count in write beats, with a shortened final burst. A count of 0 completes with no bus beat.
- R7: Each unit arrives unchanged at its destination. A byte travels on lane addr[1:0], a half-word on lane addr[1], and write data repeats the unit across all lanes.
- R8: Completion gives a one-cycle `done_o` pulse, and `en_o` reads 0 from the following cycle.
- R9: A control write with bit 0 at 0 during a transfer clears `en_o` and drops `m_req_o` in the cycle after the write edge. The next enabled transfer then runs correctly from its bases.
- R10: A control write with enable set and size code 11 does not start a transfer. `en_o` stays 0 and `err_o` becomes 1. The next accepted control write clears `err_o`.
- R11: While a transfer runs, writes to the base and count registers and control writes with bit 0 at 1 have no effect.
- R12: While `m_ready_i` is 0, a pending address phase keeps `m_req_o`, `m_addr_o` and `m_write_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 source base, 2 destination base, 3 count |
| cfg_wdata | input | 32 | Register write data |
| en_o | output | 1 | Enable bit of the control word |
| err_o | output | 1 | Reserved size code was rejected |
| done_o | output | 1 | One-cycle completion pulse |
| cur_src_o | output | ADDR_W | Current source address |
| cur_dst_o | output | ADDR_W | Current destination address |
| m_req_o | output | 1 | Address phase valid |
| m_write_o | output | 1 | Address phase is a write |
| m_size_o | output | 2 | Beat size code |
| m_addr_o | output | ADDR_W | Beat address |
| m_wdata_o | output | 32 | Write data, valid in the write data phase |
| m_rdata_i | input | 32 | Read data, sampled when the data phase completes |
| m_ready_i | input | 1 | Slave ready; 0 stretches the current data phase |

## Verification
The assertions assume that the bus slave obeys the pipeline rule: a data phase ends only on a clock edge where `m_ready_i` is 1, and the next address phase is taken at that same edge. They also assume that base addresses are aligned to the unit size and that software does not clear the enable bit in the same cycle as completion. The stimulus model answers every accepted address phase with exactly one data phase, and it drives random stall cycles. It draws bases as multiples of the unit size within separate source and destination regions, and it writes registers only while the bus is idle or inside the deliberate busy and abort cases.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

   localparam int BUS_W = 32;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } unit_size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PLAN,
      ST_READ,
      ST_WRITE,
      ST_FIN
   } seq_state_e;

   typedef struct packed {
      logic       dst_inc;
      logic       src_inc;
      logic [1:0] burst;
      unit_size_e size;
   } stream_ctrl_t;

   localparam int CB_EN    = 0;
   localparam int CB_SIZE  = 1;
   localparam int CB_BURST = 3;
   localparam int CB_SINC  = 5;
   localparam int CB_DINC  = 6;

   function automatic logic [4:0] burst_units(input logic [1:0] code);
      case (code)
         2'b00:   burst_units = 5'd1;
         2'b01:   burst_units = 5'd4;
         2'b10:   burst_units = 5'd8;
         default: burst_units = 5'd16;
      endcase
   endfunction

endpackage

// File: rtl/dma_stream_regs.sv
module dma_stream_regs
   import dma_stream_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              fin_i,
   output logic              en_o,
   output logic              err_o,
   output stream_ctrl_t      ctrl_o,
   output logic [ADDR_W-1:0] src_base_o,
   output logic [ADDR_W-1:0] dst_base_o,
   output logic [CNT_W-1:0]  cnt_o
);

   stream_ctrl_t wr_ctrl;
   logic         wr_en_bit;
   logic         wr_rsvd;

   always_comb begin
      wr_ctrl.size    = unit_size_e'(cfg_wdata[CB_SIZE +: 2]);
      wr_ctrl.burst   = cfg_wdata[CB_BURST +: 2];
      wr_ctrl.src_inc = cfg_wdata[CB_SINC];
      wr_ctrl.dst_inc = cfg_wdata[CB_DINC];
      wr_en_bit       = cfg_wdata[CB_EN];
      wr_rsvd         = (wr_ctrl.size == SZ_RSVD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o       <= 1'b0;
         err_o      <= 1'b0;
         ctrl_o     <= '0;
         src_base_o <= '0;
         dst_base_o <= '0;
         cnt_o      <= '0;
      end else begin
         if (fin_i) en_o <= 1'b0;
         if (cfg_we) begin
            case (cfg_sel)
               2'd0: begin
                  if (en_o) begin
                     if (!wr_en_bit) en_o <= 1'b0;
                  end else if (wr_en_bit && wr_rsvd) begin
                     err_o <= 1'b1;
                  end else begin
                     ctrl_o <= wr_ctrl;
                     en_o   <= wr_en_bit;
                     err_o  <= 1'b0;
                  end
               end
               2'd1: if (!en_o) src_base_o <= cfg_wdata[ADDR_W-1:0];
               2'd2: if (!en_o) dst_base_o <= cfg_wdata[ADDR_W-1:0];
               default: if (!en_o) cnt_o <= cfg_wdata[CNT_W-1:0];
            endcase
         end
      end
   end

endmodule

// File: rtl/dma_stream_buf.sv
module dma_stream_buf #(
   parameter int DEPTH     = 16,
   parameter int W         = 32,
   parameter int RESET_ENT = 1,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IDX_W-1:0] widx_i,
   input  logic [W-1:0]     wdata_i,
   input  logic [IDX_W-1:0] ridx_i,
   output logic [W-1:0]     rdata_o
);

   logic [W-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [W-1:0] q;
      logic         hit;
      assign hit    = we_i && (widx_i == IDX_W'(i));
      assign ent[i] = q;
      if (RESET_ENT != 0) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) q <= wdata_i;
         end
      end
   end

   assign rdata_o = ent[ridx_i];

endmodule

// File: rtl/dma_stream_lane.sv
module dma_stream_lane
   import dma_stream_pkg::*;
(
   input  unit_size_e       size_i,
   input  logic [1:0]       ofs_i,
   input  logic [BUS_W-1:0] bus_rdata_i,
   output logic [BUS_W-1:0] unit_o,
   input  logic [BUS_W-1:0] unit_i,
   output logic [BUS_W-1:0] bus_wdata_o
);

   always_comb begin
      case (size_i)
         SZ_BYTE: unit_o = {24'b0, bus_rdata_i[{ofs_i, 3'b000} +: 8]};
         SZ_HALF: unit_o = {16'b0, bus_rdata_i[{ofs_i[1], 4'b0000} +: 16]};
         default: unit_o = bus_rdata_i;
      endcase
   end

   always_comb begin
      case (size_i)
         SZ_BYTE: bus_wdata_o = {4{unit_i[7:0]}};
         SZ_HALF: bus_wdata_o = {2{unit_i[15:0]}};
         default: bus_wdata_o = unit_i;
      endcase
   end

endmodule

// File: rtl/dma_stream_seq.sv
module dma_stream_seq
   import dma_stream_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int DEPTH  = 16,
   localparam int BEAT_W = $clog2(DEPTH + 1),
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  stream_ctrl_t      ctrl_i,
   input  logic [ADDR_W-1:0] src_base_i,
   input  logic [ADDR_W-1:0] dst_base_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              m_ready_i,
   output logic              fin_o,
   output logic              m_req_o,
   output logic              m_write_o,
   output unit_size_e        m_size_o,
   output logic [ADDR_W-1:0] m_addr_o,
   output logic [ADDR_W-1:0] cur_src_o,
   output logic [ADDR_W-1:0] cur_dst_o,
   output logic              buf_we_o,
   output logic [IDX_W-1:0]  buf_idx_o,
   output logic [1:0]        dp_ofs_o
);

   localparam logic [BEAT_W-1:0] ONE_BEAT = BEAT_W'(1);

   seq_state_e        state;
   logic [CNT_W-1:0]  remain;
   logic [BEAT_W-1:0] beats, acnt, dcnt;
   logic              dp_pend;
   logic [IDX_W-1:0]  dp_idx;
   logic [1:0]        dp_ofs;

   logic              moving, is_wr, active, accept, dp_done;
   logic [ADDR_W-1:0] step;
   logic [CNT_W-1:0]  blen, next_beats;

   always_comb begin
      moving     = (state == ST_READ) || (state == ST_WRITE);
      is_wr      = (state == ST_WRITE);
      active     = moving && (acnt != beats) && en_i;
      accept     = active && m_ready_i;
      dp_done    = moving && dp_pend && m_ready_i;
      step       = ADDR_W'(1) << ctrl_i.size;
      blen       = CNT_W'(burst_units(ctrl_i.burst));
      next_beats = (remain < blen) ? remain : blen;
   end

   assign m_req_o   = active;
   assign m_write_o = is_wr;
   assign m_size_o  = ctrl_i.size;
   assign m_addr_o  = is_wr ? cur_dst_o : cur_src_o;
   assign fin_o     = (state == ST_FIN);
   assign buf_we_o  = dp_done && !is_wr;
   assign buf_idx_o = dp_idx;
   assign dp_ofs_o  = dp_ofs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         remain    <= '0;
         beats     <= '0;
         acnt      <= '0;
         dcnt      <= '0;
         dp_pend   <= 1'b0;
         dp_idx    <= '0;
         dp_ofs    <= '0;
         cur_src_o <= '0;
         cur_dst_o <= '0;
      end else if (!en_i) begin
         state   <= ST_IDLE;
         acnt    <= '0;
         dcnt    <= '0;
         dp_pend <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               cur_src_o <= src_base_i;
               cur_dst_o <= dst_base_i;
               remain    <= cnt_i;
               state     <= ST_PLAN;
            end
            ST_PLAN: begin
               if (remain == '0) begin
                  state <= ST_FIN;
               end else begin
                  beats <= BEAT_W'(next_beats);
                  acnt  <= '0;
                  dcnt  <= '0;
                  state <= ST_READ;
               end
            end
            ST_READ, ST_WRITE: begin
               if (m_ready_i) dp_pend <= accept;
               if (accept) begin
                  acnt   <= acnt + ONE_BEAT;
                  dp_idx <= acnt[IDX_W-1:0];
                  dp_ofs <= m_addr_o[1:0];
                  if (!is_wr && ctrl_i.src_inc) cur_src_o <= cur_src_o + step;
                  if (is_wr && ctrl_i.dst_inc)  cur_dst_o <= cur_dst_o + step;
               end
               if (dp_done) begin
                  dcnt <= dcnt + ONE_BEAT;
                  if ((dcnt + ONE_BEAT) == beats) begin
                     acnt <= '0;
                     dcnt <= '0;
                     if (is_wr) begin
                        remain <= remain - CNT_W'(beats);
                        state  <= ST_PLAN;
                     end else begin
                        state <= ST_WRITE;
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dma_stream.sv
module dma_stream
   import dma_stream_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 16,
   parameter int BUF_DEPTH = 16,
   parameter int BUF_RESET = 1,
   localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic              en_o,
   output logic              err_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] cur_src_o,
   output logic [ADDR_W-1:0] cur_dst_o,
   output logic              m_req_o,
   output logic              m_write_o,
   output logic [1:0]        m_size_o,
   output logic [ADDR_W-1:0] m_addr_o,
   output logic [31:0]       m_wdata_o,
   input  logic [31:0]       m_rdata_i,
   input  logic              m_ready_i
);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("dma_stream: ADDR_W must lie in 8..32");
   end
   if (CNT_W < 5 || CNT_W > 32) begin : g_bad_cnt
      $error("dma_stream: CNT_W must lie in 5..32");
   end
   if (BUF_DEPTH < 16 || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dma_stream: BUF_DEPTH must be a power of two of at least 16");
   end

   stream_ctrl_t      ctrl_q;
   logic [ADDR_W-1:0] src_base, dst_base;
   logic [CNT_W-1:0]  unit_cnt;
   logic              fin;
   unit_size_e        bus_size;
   logic              buf_we;
   logic [IDX_W-1:0]  buf_idx;
   logic [1:0]        dp_ofs;
   logic [31:0]       unit_in, unit_out;

   dma_stream_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .fin_i      (fin),
      .en_o       (en_o),
      .err_o      (err_o),
      .ctrl_o     (ctrl_q),
      .src_base_o (src_base),
      .dst_base_o (dst_base),
      .cnt_o      (unit_cnt)
   );

   dma_stream_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(BUF_DEPTH)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_o),
      .ctrl_i     (ctrl_q),
      .src_base_i (src_base),
      .dst_base_i (dst_base),
      .cnt_i      (unit_cnt),
      .m_ready_i  (m_ready_i),
      .fin_o      (fin),
      .m_req_o    (m_req_o),
      .m_write_o  (m_write_o),
      .m_size_o   (bus_size),
      .m_addr_o   (m_addr_o),
      .cur_src_o  (cur_src_o),
      .cur_dst_o  (cur_dst_o),
      .buf_we_o   (buf_we),
      .buf_idx_o  (buf_idx),
      .dp_ofs_o   (dp_ofs)
   );

   dma_stream_lane i_lane (
      .size_i      (bus_size),
      .ofs_i       (dp_ofs),
      .bus_rdata_i (m_rdata_i),
      .unit_o      (unit_in),
      .unit_i      (unit_out),
      .bus_wdata_o (m_wdata_o)
   );

   dma_stream_buf #(.DEPTH(BUF_DEPTH), .W(32), .RESET_ENT(BUF_RESET)) i_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (buf_we),
      .widx_i  (buf_idx),
      .wdata_i (unit_in),
      .ridx_i  (buf_idx),
      .rdata_o (unit_out)
   );

   assign m_size_o = bus_size;
   assign done_o   = fin;

endmodule

// File: rtl/dma_stream_chk.sv
module dma_stream_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [1:0]        cfg_sel,
   input logic [31:0]       cfg_wdata,
   input logic              en_o,
   input logic              err_o,
   input logic              done_o,
   input logic              m_req_o,
   input logic              m_ready_i,
   input logic              m_write_o,
   input logic [1:0]        m_size_o,
   input logic [ADDR_W-1:0] m_addr_o,
   input logic [ADDR_W-1:0] cur_src_o,
   input logic              src_inc
);

   logic ctrl_wr, stop_wr;
   assign ctrl_wr = cfg_we && (cfg_sel == 2'd0);
   assign stop_wr = ctrl_wr && !cfg_wdata[0];

   // R12
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req_o && !m_ready_i && !stop_wr) |=>
         (m_req_o && $stable(m_addr_o) && $stable(m_write_o)));

   // R4
   src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req_o && m_ready_i && !m_write_o && src_inc) |=>
         (cur_src_o == $past(cur_src_o) + (ADDR_W'(1) << $past(m_size_o))));

   // R3
   src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req_o && m_ready_i && !m_write_o && !src_inc) |=> $stable(cur_src_o));

   // R8
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!en_o && !done_o));

   // R10
   rsvd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !en_o && cfg_wdata[0] && cfg_wdata[2:1] == 2'b11) |=>
         (!en_o && err_o));

   // R2
   size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_req_o |-> (en_o && m_size_o != 2'b11));

   // R9
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o && stop_wr) |=> (!en_o && !m_req_o));

endmodule

bind dma_stream dma_stream_chk #(.ADDR_W(ADDR_W)) i_dma_stream_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata),
   .en_o      (en_o),
   .err_o     (err_o),
   .done_o    (done_o),
   .m_req_o   (m_req_o),
   .m_ready_i (m_ready_i),
   .m_write_o (m_write_o),
   .m_size_o  (m_size_o),
   .m_addr_o  (m_addr_o),
   .cur_src_o (cur_src_o),
   .src_inc   (ctrl_q.src_inc)
);

// File: tb/test_dma_stream.sv
module test_dma_stream;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic        en_o, err_o, done_o, m_req_o, m_write_o;
   logic [1:0]  m_size_o;
   logic [31:0] cur_src_o, cur_dst_o, m_addr_o, m_wdata_o, m_rdata_i;
   logic        m_ready_i;

   always #2.5 clk = ~clk;

   dma_stream i_dma_stream (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .en_o(en_o), .err_o(err_o), .done_o(done_o), .cur_src_o(cur_src_o), .cur_dst_o(cur_dst_o),
      .m_req_o(m_req_o), .m_write_o(m_write_o), .m_size_o(m_size_o), .m_addr_o(m_addr_o),
      .m_wdata_o(m_wdata_o), .m_rdata_i(m_rdata_i), .m_ready_i(m_ready_i)
   );

   // ---------------- slave memory model ----------------
   logic [7:0] mem [256];
   logic [7:0] exp_mem [256];
   logic       dph_v, dph_w;
   logic [7:0] dph_a;
   logic [1:0] dph_s;
   logic [7:0] wa;
   int         rd_total, wr_total, rd_run, max_run;

   assign wa = {dph_a[7:2], 2'b00};
   assign m_rdata_i = {mem[wa + 8'd3], mem[wa + 8'd2], mem[wa + 8'd1], mem[wa]};

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dph_v     <= 1'b0;
         dph_w     <= 1'b0;
         dph_a     <= 8'd0;
         dph_s     <= 2'd0;
         m_ready_i <= 1'b1;
      end else begin
         if (dph_v && dph_w && m_ready_i) begin
            case (dph_s)
               2'd0: mem[dph_a] = m_wdata_o[{dph_a[1:0], 3'b000} +: 8];
               2'd1: begin
                  mem[{dph_a[7:1], 1'b0}] = m_wdata_o[{dph_a[1], 4'b0000} +: 8];
                  mem[{dph_a[7:1], 1'b1}] = m_wdata_o[{dph_a[1], 4'b1000} +: 8];
               end
               default: for (int k = 0; k < 4; k++) mem[wa + 8'(k)] = m_wdata_o[8*k +: 8];
            endcase
         end
         if (m_req_o && m_ready_i) begin
            if (m_write_o) begin
               wr_total = wr_total + 1;
               rd_run   = 0;
            end else begin
               rd_total = rd_total + 1;
               rd_run   = rd_run + 1;
               if (rd_run > max_run) max_run = rd_run;
            end
         end
         if (m_ready_i) begin
            dph_v <= m_req_o;
            dph_w <= m_write_o;
            dph_a <= m_addr_o[7:0];
            dph_s <= m_size_o;
         end
         m_ready_i <= ($urandom_range(0, 3) != 0);
      end
   end

   // ---------------- bookkeeping ----------------
   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
      cfg_sel   = sel;
      cfg_wdata = data;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_word(input int w, input int b, input bit si, input bit di, input bit en);
      ctrl_word = {25'd0, di, si, 2'(b), 2'(w), en};
   endfunction

   function automatic int burst_len(input int b);
      case (b)
         0: burst_len = 1;
         1: burst_len = 4;
         2: burst_len = 8;
         default: burst_len = 16;
      endcase
   endfunction

   function automatic int min2(input int a, input int b);
      min2 = (a < b) ? a : b;
   endfunction

   task automatic fill_mem();
      for (int i = 0; i < 256; i++) begin
         mem[i]     = 8'($urandom);
         exp_mem[i] = mem[i];
      end
      rd_total = 0;
      wr_total = 0;
      rd_run   = 0;
      max_run  = 0;
   endtask

   task automatic model_copy(input int src, input int dst, input int sz, input int cnt, input bit si, input bit di);
      for (int u = 0; u < cnt; u++) begin
         int s, d;
         s = src + (si ? u * sz : 0);
         d = dst + (di ? u * sz : 0);
         for (int k = 0; k < sz; k++) exp_mem[(d + k) & 255] = exp_mem[(s + k) & 255];
      end
   endtask

   task automatic start_xfer(input int w, input int b, input bit si, input bit di, input int cnt,
                             input int src, input int dst);
      fill_mem();
      model_copy(src, dst, 1 << w, cnt, si, di);
      cfg_write(2'd1, 32'(src));
      cfg_write(2'd2, 32'(dst));
      cfg_write(2'd3, 32'(cnt));
      cfg_write(2'd0, ctrl_word(w, b, si, di, 1'b1));
   endtask

   task automatic finish_xfer(input int w, input int b, input bit si, input bit di, input int cnt,
                              input int src, input int dst);
      bit got;
      int sz;
      int bad;
      longint exp_src, exp_dst;
      got = 1'b0;
      sz  = 1 << w;
      for (int t = 0; t < 3000 && !got; t++) begin
         if (done_o) got = 1'b1;
         else @(negedge clk);
      end
      check(got, "R8 done pulse", got, 1);
      @(negedge clk);
      check(!en_o && !done_o, "R8 enable self-clear", en_o, 0);
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
      check(bad == 0, "R7 destination content", bad, 0);
      check(rd_total == cnt && wr_total == cnt, "R6 beat totals", rd_total * 1000 + wr_total, cnt * 1001);
      check(max_run == min2(burst_len(b), cnt), "R5 read gather run", max_run, min2(burst_len(b), cnt));
      exp_src = si ? longint'(src + cnt * sz) : longint'(src);
      exp_dst = di ? longint'(dst + cnt * sz) : longint'(dst);
      check(cur_src_o == 32'(exp_src), si ? "R2 source address step" : "R3 source address fixed",
            cur_src_o, exp_src);
      check(cur_dst_o == 32'(exp_dst), di ? "R2 destination address step" : "R3 destination address fixed",
            cur_dst_o, exp_dst);
   endtask

   task automatic run_xfer(input int w, input int b, input bit si, input bit di, input int cnt,
                           input int src, input int dst);
      start_xfer(w, b, si, di, cnt, src, dst);
      finish_xfer(w, b, si, di, cnt, src, dst);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R8 watchdog expired actual=1 expected=0");
      summary();
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) mem[i] = 8'd0;
      rd_total = 0; wr_total = 0; rd_run = 0; max_run = 0;
      repeat (3) @(negedge clk);
      check(!en_o && !err_o && !done_o && !m_req_o, "R1 reset outputs",
            {en_o, err_o, done_o, m_req_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // directed: word, burst 4, both increment, count 10 (shortened final burst)
      run_xfer(2, 1, 1, 1, 10, 8, 160);
      // directed: bytes at odd offsets
      run_xfer(0, 2, 1, 1, 5, 1, 131);
      // directed: half-words into a fixed destination
      run_xfer(1, 1, 1, 0, 6, 6, 202);
      // directed: fixed source, 16-beat burst longer than count
      run_xfer(2, 3, 0, 1, 7, 20, 128);
      // directed: count 0
      run_xfer(2, 3, 1, 1, 0, 0, 128);

      // R4: source address advances right after the read address phase
      begin
         bit seen;
         int guard;
         start_xfer(2, 2, 1, 1, 8, 16, 176);
         seen = 1'b0;
         guard = 0;
         while (!seen && guard < 200) begin
            if (m_req_o && m_ready_i && !m_write_o) seen = 1'b1;
            @(negedge clk);
            guard++;
         end
         check(seen && cur_src_o == 32'd20, "R4 source address after address phase", cur_src_o, 20);
         finish_xfer(2, 2, 1, 1, 8, 16, 176);
      end

      // R10: reserved size rejected, then cleared by an accepted control write
      cfg_write(2'd0, ctrl_word(3, 1, 1, 1, 1'b1));
      check(!en_o && err_o, "R10 reserved size rejected", {en_o, err_o}, 1);
      begin
         int req_seen;
         req_seen = 0;
         for (int i = 0; i < 10; i++) begin
            if (m_req_o) req_seen++;
            @(negedge clk);
         end
         check(req_seen == 0, "R10 no bus activity after reject", req_seen, 0);
      end
      start_xfer(1, 0, 1, 1, 3, 0, 140);
      check(!err_o, "R10 error cleared by accepted write", err_o, 0);
      finish_xfer(1, 0, 1, 1, 3, 0, 140);

      // R11: writes during a transfer are ignored
      start_xfer(2, 1, 1, 1, 12, 4, 136);
      repeat (5) @(negedge clk);
      cfg_write(2'd1, 32'd100);
      cfg_write(2'd3, 32'd2);
      cfg_write(2'd0, ctrl_word(0, 0, 0, 0, 1'b1));
      finish_xfer(2, 1, 1, 1, 12, 4, 136);
      check(1'b1, "R11 busy writes ignored (covered by the checks above)", 0, 0);

      // R9: abort in the middle, then a fresh transfer
      start_xfer(2, 3, 1, 1, 24, 0, 128);
      repeat (15) @(negedge clk);
      cfg_write(2'd0, 32'd0);
      check(!en_o && !m_req_o, "R9 abort drops request", {en_o, m_req_o}, 0);
      begin
         int req_seen;
         req_seen = 0;
         for (int i = 0; i < 8; i++) begin
            if (m_req_o || done_o) req_seen++;
            @(negedge clk);
         end
         check(req_seen == 0, "R9 stream idle after abort", req_seen, 0);
      end
      run_xfer(1, 1, 1, 1, 9, 10, 150);

      // random transfers
      for (int n = 0; n < 24; n++) begin
         int w, b, cnt, sz, span, src, dst;
         bit si, di;
         w    = $urandom_range(0, 2);
         b    = $urandom_range(0, 3);
         si   = 1'($urandom_range(0, 1));
         di   = 1'($urandom_range(0, 1));
         cnt  = $urandom_range(0, 20);
         sz   = 1 << w;
         span = si ? ((cnt == 0) ? sz : cnt * sz) : sz;
         src  = $urandom_range(0, (128 - span) / sz) * sz;
         span = di ? ((cnt == 0) ? sz : cnt * sz) : sz;
         dst  = 128 + $urandom_range(0, (128 - span) / sz) * sz;
         run_xfer(w, b, si, di, cnt, src, dst);
      end

      summary();
      $finish;
   end

endmodule